// File: doc/BRIEF.md
# Packet Error Interrupt Register Slice

This block holds the interrupt bits for the error signal of a packet receiver. The receiver drives a live status line. That line is high while the packet now being handled is in error, and it drops for at least one cycle before each new packet. From this line the block keeps three one-bit registers:

- a sticky pending bit, which software clears by writing 1;
- an enable bit that masks the interrupt;
- a read-only summary bit that shows an outstanding enabled interrupt.

Software reaches these bits, and the raw status, through a single-cycle addressed port. The block also drives a registered interrupt request.

A parameter selects how the pending bit is set. In edge mode it is set only by a 0-to-1 change of the status. Each errored packet therefore raises exactly one event, even when errored packets follow back to back, and firmware can clear the bit without first masking the interrupt. In level mode it is set on every cycle the status is high.

Top module: `pktErrIrq`

## Requirements
- R1: After reset, the enable bit, the pending bit and the interrupt request are 0, and every address reads as all zeros.
- R2: Address 0 reads the live status input in bit 0. Writes to address 0 have no effect.
- R3: Address 1 is the enable bit. A write stores write-data bit 0, and a read returns it in bit 0.
- R4: In edge mode (EDGE_MODE=1), the pending bit (address 2, bit 0) is set at the clock edge where the status is 1 and was 0 on the previous edge. A status that stays high does not set the bit again after it has been cleared.
- R5: Writing 1 to address 2 clears the pending bit when no set event occurs in the same cycle. Writing 0 to address 2 leaves the bit unchanged.
- R6: If a set event and a write-1-to-clear fall in the same cycle, the pending bit ends up set.
- R7: Address 3 bit 0 reads 1 exactly when the pending bit and the enable bit are both 1. Writes to address 3 have no effect.
- R8: The interrupt request is registered. It equals pending AND enable as they stood one clock edge earlier.
- R9: In edge mode, a status that is already high when reset is released does not set the pending bit. The first rise after reset does set it.
- R10: In level mode (EDGE_MODE=0), the pending bit is set on every cycle the status is 1, so a clear written while the status is high is overridden. Dropping the enable removes the request one edge later.
- R11: A single low cycle of the status between two errored packets produces a second, separate pending event.
- R12: Unmapped addresses read as 0, and the upper bits of read data are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errStatus | input | 1 | Live error status of the current packet |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrBit | input | 1 | Write data (all registers are one bit wide) |
| regRdData | output | DATA_W | Read data, combinational from the address |
| irqReq | output | 1 | Registered interrupt request |

## Verification
A stuck or wrong previous-status flop shows up within one cycle of a status rise. The pending bit then either fails to appear at address 2, or it reappears after a clear while the status is still high. A wrong clear priority shows up on the cycle after a combined edge-and-clear, when the pending bit reads 0. Errors in the request path show up at irqReq exactly one edge after pending or enable changes, either as a missing one-cycle delay or as a request that ignores the mask.

// File: rtl/pktErrIrqPkg.sv
package pktErrIrqPkg;
  // strobes from register decode to the state datapath
  typedef struct packed {
    logic enWr;
    logic enVal;
    logic pendClr;
  } regStrobe_t;

  // state visible to the read path
  typedef struct packed {
    logic status;
    logic enable;
    logic pending;
    logic summary;
  } regView_t;
endpackage

// File: rtl/irqRegCtrl.sv
module irqRegCtrl
  import pktErrIrqPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 0,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 1,
  parameter logic [ADDR_W-1:0] ADDR_PEND = 2,
  parameter logic [ADDR_W-1:0] ADDR_SUMMARY = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit,
  input  regView_t          view,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    strobe.enWr    = wrEn && (addr == ADDR_ENABLE);
    strobe.enVal   = wrBit;
    strobe.pendClr = wrEn && (addr == ADDR_PEND) && wrBit;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_STATUS:  rdData[0] = view.status;
      ADDR_ENABLE:  rdData[0] = view.enable;
      ADDR_PEND:    rdData[0] = view.pending;
      ADDR_SUMMARY: rdData[0] = view.summary;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqRegDatapath.sv
module irqRegDatapath
  import pktErrIrqPkg::*;
#(
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       statusIn,
  input  regStrobe_t strobe,
  output regView_t   view,
  output logic       prevQ,
  output logic       armedQ,
  output logic       irqReq
);
  logic enableQ, pendingQ, irqQ, setEvent;

  generate
    if (EDGE_MODE) begin : g_edge
      assign setEvent = armedQ && statusIn && !prevQ;
    end else begin : g_level
      assign setEvent = armedQ && statusIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ    <= 1'b0;
      armedQ   <= 1'b0;
      enableQ  <= 1'b0;
      pendingQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      prevQ  <= statusIn;
      armedQ <= 1'b1;
      if (strobe.enWr) enableQ <= strobe.enVal;
      if (setEvent) pendingQ <= 1'b1;
      else if (strobe.pendClr) pendingQ <= 1'b0;
      irqQ <= pendingQ && enableQ;
    end
  end

  always_comb begin
    view.status  = statusIn;
    view.enable  = enableQ;
    view.pending = pendingQ;
    view.summary = pendingQ && enableQ;
  end
  assign irqReq = irqQ;
endmodule

// File: rtl/pktErrIrq.sv
module pktErrIrq
  import pktErrIrqPkg::*;
#(
  parameter bit EDGE_MODE = 1'b1,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 0,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 1,
  parameter logic [ADDR_W-1:0] ADDR_PEND = 2,
  parameter logic [ADDR_W-1:0] ADDR_SUMMARY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errStatus,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrBit,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqReq
);
  regStrobe_t strobe;
  regView_t   view;
  logic       prevQ, armedQ;

  irqRegCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_STATUS(ADDR_STATUS),
    .ADDR_ENABLE(ADDR_ENABLE), .ADDR_PEND(ADDR_PEND), .ADDR_SUMMARY(ADDR_SUMMARY)
  ) i_ctrl (
    .wrEn(regWrEn), .addr(regAddr), .wrBit(regWrBit),
    .view(view), .strobe(strobe), .rdData(regRdData)
  );

  irqRegDatapath #(.EDGE_MODE(EDGE_MODE)) i_dp (
    .clk(clk), .rstN(rstN), .statusIn(errStatus), .strobe(strobe),
    .view(view), .prevQ(prevQ), .armedQ(armedQ), .irqReq(irqReq)
  );
endmodule

// File: rtl/pktErrIrqChk.sv
module pktErrIrqChk #(
  parameter bit EDGE_MODE = 1'b1,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 0,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 1,
  parameter logic [ADDR_W-1:0] ADDR_PEND = 2,
  parameter logic [ADDR_W-1:0] ADDR_SUMMARY = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              errStatus,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrBit,
  input logic              rdBit0,
  input logic              pendingQ,
  input logic              enableQ,
  input logic              prevQ,
  input logic              armedQ,
  input logic              irqReq
);
  // R2
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |-> (rdBit0 == errStatus));

  // R3
  enable_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_ENABLE) |=> (enableQ == $past(regWrBit)));

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_PEND && regWrBit && !errStatus) |=> !pendingQ);

  // R5
  pend_write0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_PEND && !regWrBit && pendingQ) |=> pendingQ);

  // R7
  summary_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_SUMMARY) |-> (rdBit0 == (pendingQ && enableQ)));

  // R8
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |=> (irqReq == $past(pendingQ && enableQ)));

  generate
    if (EDGE_MODE) begin : g_edgeChk
      // R4
      rise_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
        (armedQ && errStatus && !prevQ) |=> pendingQ);
      // R9
      first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!armedQ && !pendingQ) |=> !pendingQ);
    end else begin : g_levelChk
      // R10
      level_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
        (armedQ && errStatus) |=> pendingQ);
    end
  endgenerate
endmodule

bind pktErrIrq pktErrIrqChk #(
  .EDGE_MODE(EDGE_MODE), .ADDR_W(ADDR_W), .ADDR_STATUS(ADDR_STATUS),
  .ADDR_ENABLE(ADDR_ENABLE), .ADDR_PEND(ADDR_PEND), .ADDR_SUMMARY(ADDR_SUMMARY)
) u_chk (
  .clk(clk), .rstN(rstN), .errStatus(errStatus), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrBit(regWrBit), .rdBit0(regRdData[0]),
  .pendingQ(view.pending), .enableQ(view.enable), .prevQ(prevQ),
  .armedQ(armedQ), .irqReq(irqReq)
);

// File: tb/test_pktErrIrq.sv
module test_pktErrIrq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errStatus = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrBit = 1'b0;
  logic [7:0] regRdData, rdDataL;
  logic irqReq, irqReqL;
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pktErrIrq #(.EDGE_MODE(1'b1)) i_pktErrIrq (
    .clk(clk), .rstN(rstN), .errStatus(errStatus), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrBit(regWrBit), .regRdData(regRdData), .irqReq(irqReq));

  pktErrIrq #(.EDGE_MODE(1'b0)) i_pktErrIrqLvl (
    .clk(clk), .rstN(rstN), .errStatus(errStatus), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrBit(regWrBit), .regRdData(rdDataL), .irqReq(irqReqL));

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic readEdge(input int a, output int v);
    regAddr = 4'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic readLvl(input int a, output int v);
    regAddr = 4'(a);
    #1 v = int'(rdDataL);
  endtask

  task automatic regWrite(input int a, input bit b);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrBit = b;
    @(negedge clk);
    regWrEn = 1'b0; regWrBit = 1'b0;
  endtask

  task automatic doReset(input bit statusLevel);
    @(negedge clk);
    rstN = 1'b0; errStatus = statusLevel;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic newPacket();  // one low cycle, then high
    @(negedge clk) errStatus = 1'b0;
    @(negedge clk) errStatus = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    int v;
    doReset(1'b0);
    for (int a = 0; a < 6; a++) begin
      readEdge(a, v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset irq", int'(irqReq), 0);
  endtask

  task automatic tEdgeSet();
    int v;
    @(negedge clk) errStatus = 1'b1;
    readEdge(0, v); check("R2 status live", v, 1);
    @(negedge clk);
    readEdge(2, v); check("R4 pending on rise", v, 1);
    readEdge(3, v); check("R7 summary masked", v, 0);
    repeat (3) @(negedge clk);
    regWrite(2, 1'b1);
    readEdge(2, v); check("R5 clear", v, 0);
    repeat (3) @(negedge clk);
    readEdge(2, v); check("R4 no reset on held level", v, 0);
  endtask

  task automatic tEnableIrq();
    int v;
    regWrite(1, 1'b1);
    readEdge(1, v); check("R3 enable readback", v, 1);
    newPacket();
    readEdge(2, v); check("R11 second packet event", v, 1);
    readEdge(3, v); check("R7 summary set", v, 1);
    check("R8 irq delayed one edge", int'(irqReq), 0);
    @(negedge clk);
    check("R8 irq asserted", int'(irqReq), 1);
    regWrite(2, 1'b1);
    check("R8 irq lags clear", int'(irqReq), 1);
    @(negedge clk);
    check("R8 irq drops", int'(irqReq), 0);
  endtask

  task automatic tIgnoredWrites();
    int v;
    newPacket();
    regWrite(2, 1'b0);
    readEdge(2, v); check("R5 write0 keeps pending", v, 1);
    regWrite(0, 1'b0);
    readEdge(0, v); check("R2 status write ignored", v, 1);
    regWrite(3, 1'b0);
    readEdge(3, v); check("R7 summary write ignored", v, 1);
    readEdge(1, v); check("R7 enable untouched", v, 1);
    readEdge(5, v); check("R12 unmapped reads 0", v, 0);
    readEdge(15, v); check("R12 top address reads 0", v, 0);
  endtask

  task automatic tSetWins();
    int v;
    @(negedge clk) errStatus = 1'b0;
    @(negedge clk);
    errStatus = 1'b1; regWrEn = 1'b1; regAddr = 4'd2; regWrBit = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrBit = 1'b0;
    readEdge(2, v); check("R6 set beats clear", v, 1);
    regWrite(2, 1'b1);
    readEdge(2, v); check("R5 clear after collision", v, 0);
  endtask

  task automatic tMask();
    int v;
    regWrite(1, 1'b0);
    newPacket();
    readEdge(2, v); check("R4 pending while masked", v, 1);
    readEdge(3, v); check("R7 summary masked", v, 0);
    @(negedge clk);
    check("R8 masked irq low", int'(irqReq), 0);
    regWrite(2, 1'b1);
  endtask

  task automatic tResetHigh();
    int v;
    doReset(1'b1);
    repeat (3) @(negedge clk);
    readEdge(2, v); check("R9 high through reset no event", v, 0);
    newPacket();
    readEdge(2, v); check("R9 first rise after reset", v, 1);
  endtask

  task automatic tLevel();
    int v;
    doReset(1'b0);
    regWrite(1, 1'b1);
    @(negedge clk) errStatus = 1'b1;
    @(negedge clk);
    readLvl(2, v); check("R10 level sets", v, 1);
    regWrite(2, 1'b1);
    readLvl(2, v); check("R10 clear overridden", v, 1);
    @(negedge clk);
    check("R10 level irq", int'(irqReqL), 1);
    regWrite(1, 1'b0);
    check("R10 irq lags mask", int'(irqReqL), 1);
    @(negedge clk);
    check("R10 irq masked", int'(irqReqL), 0);
    errStatus = 1'b0;
    regWrite(2, 1'b1);
    readLvl(2, v); check("R10 clear once low", v, 0);
  endtask

  initial begin
    tReset();
    tEdgeSet();
    tEnableIrq();
    tIgnoredWrites();
    tSetWins();
    tMask();
    tResetHigh();
    tLevel();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule